// File: doc/BRIEF.md
# Multi-Format Asynchronous Serial Channel

This block is one full-duplex asynchronous serial channel. It has a receiver that samples at 16 times the bit rate and a transmitter that runs on the same baud tick. The frame format is chosen at run time from five layouts: 7 data bits, 7 bits with parity, 8 bits, 8 bits with parity, and 9 bits. Parity may be even or odd. Every frame has one start bit (low), the data bits sent least significant first, an optional parity bit, and one stop bit (high). The line idles high.

Received bits collect in a shift register. At the hand-off point they move into a holding register, which the host reads and then acknowledges. The receive interrupt, the hand-off and the overrun decision all happen at one point, and that point depends on the format. In the two nine-bit-long formats (8 data bits with parity, and 9 data bits) it is the centre of the last bit, so the host can react before the stop bit has arrived. In every other format it is the stop-bit decision. The stop bit is always judged by a 2-of-3 vote. Parity, framing and overrun errors are sticky flags, and a clear strobe resets them.

The transmitter takes a parallel word and a write strobe. It starts the frame on the next baud tick. It raises its interrupt one oversample tick before the stop bit begins.

Top module: `uart_fmt_trx`

## Requirements
- R1: `fmt` selects the frame layout as follows: 0 = 7 bits, 1 = 7 bits + parity, 2 = 8 bits, 3 = 8 bits + parity, 4 = 9 bits (5 to 7 behave as 2). Data travels LSB first. Received data lands right-aligned in `rx_buf`, and the unused upper bits read 0.
- R2: In formats 3 and 4, `rx_irq` pulses for one cycle at the centre sample (tick 8) of the last bit, which is the parity bit or data bit 8. This happens while the stop bit has not yet started.
- R3: In formats 0, 1 and 2 (and 5 to 7), `rx_irq` pulses for one cycle at the stop-bit decision, which is oversample tick 9 of the stop bit.
- R4: The stop bit is sampled at ticks 7, 8 and 9. `ferr` sets at tick 9 of the stop bit when at least two of those samples are 0, in every format. A single low sample does not set it.
- R5: In parity formats, the parity bit is checked at its centre against the parity of the received data bits, with `par_odd` = 0 for even and 1 for odd. A mismatch sets `perr`.
- R6: If a frame reaches the hand-off point while `rx_full` is set and no `rd_ack` arrives in that cycle, the new data is dropped, `rx_buf` keeps its value, and `oerr` sets in the cycle of `rx_irq`.
- R7: A hand-off loads `rx_buf` and sets `rx_full`. `rd_ack` clears `rx_full`. While `rx_full` is set and no `rd_ack` arrives, `rx_buf` does not change.
- R8: A falling edge on `rx` that is no longer low at tick 8 is discarded. It produces no interrupt and no buffer change, and the receiver then accepts the next frame normally.
- R9: `tx` idles high. A write starts the frame on the next baud tick: a start bit of 0, then the data bits LSB first, then the parity bit if the format has one, then a stop bit of 1. Each bit lasts 16 ticks.
- R10: `tx_irq` pulses for one cycle exactly 16·(N+1)−1 baud ticks after the tick that drove the start bit, where N is the number of data bits plus parity bits. This is one tick before the stop bit is driven.
- R11: A `tx_wr` that arrives while a frame is pending or being sent is ignored.
- R12: `perr`, `ferr` and `oerr` stay set until `err_clr`. If an error and `err_clr` occur in the same cycle, the error wins.
- R13: After reset: `tx` = 1, `rx_full` = 0, `rx_buf` = 0, all flags and interrupts are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| rx | input | 1 | Serial receive line |
| fmt | input | 3 | Frame format select |
| par_odd | input | 1 | 1 = odd parity, 0 = even |
| tx_data | input | 9 | Word to transmit |
| tx_wr | input | 1 | Transmit write strobe |
| rd_ack | input | 1 | Host has read `rx_buf` |
| err_clr | input | 1 | Clears the error flags |
| tx | output | 1 | Serial transmit line |
| rx_buf | output | 9 | Receive holding register |
| rx_full | output | 1 | Holding register has unread data |
| rx_irq | output | 1 | Receive interrupt pulse |
| tx_irq | output | 1 | Transmit interrupt pulse |
| perr | output | 1 | Sticky parity error |
| ferr | output | 1 | Sticky framing error |
| oerr | output | 1 | Sticky overrun error |

## Verification
In the formats where the hand-off waits for the stop bit, three things happen in the same cycle: the stop-bit vote that sets `ferr`, the hand-off, and `rx_irq`. In the 8-bit-plus-parity format, the parity verdict coincides with `rx_irq` in the same way. The bench provokes these coincidences in two ways. It drives the stop bit with a three-tick low glitch, and it drives a wrong parity bit in format 3. At the interrupt cycle it checks that the flag has its expected value. It checks `ferr` again after the frame, to confirm that the early formats raise it only one bit later. The overrun case has its own coincidence: `oerr` must rise together with the interrupt of the second unacknowledged frame, while `rx_buf` still holds the first word.

// File: rtl/uart_fmt_trx.sv
module uart_fmt_trx #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic       rx,
  input  logic [2:0] fmt,
  input  logic       par_odd,
  input  logic [8:0] tx_data,
  input  logic       tx_wr,
  input  logic       rd_ack,
  input  logic       err_clr,
  output logic       tx,
  output logic [8:0] rx_buf,
  output logic       rx_full,
  output logic       rx_irq,
  output logic       tx_irq,
  output logic       perr,
  output logic       ferr,
  output logic       oerr
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] CTR  = CW'(OVS / 2);
  localparam logic [CW-1:0] S_LO = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] S_HI = CW'(OVS / 2 + 1);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);
  localparam logic [CW-1:0] PRE  = CW'(OVS - 2);

  logic [3:0] nd, nb;
  logic       hp, early;
  logic [8:0] dmask;

  always_comb begin
    case (fmt)
      3'd0:    begin nd = 4'd7; hp = 1'b0; end
      3'd1:    begin nd = 4'd7; hp = 1'b1; end
      3'd3:    begin nd = 4'd8; hp = 1'b1; end
      3'd4:    begin nd = 4'd9; hp = 1'b0; end
      default: begin nd = 4'd8; hp = 1'b0; end
    endcase
  end

  assign nb    = nd + {3'd0, hp};
  assign early = (nb == 4'd9);
  assign dmask = 9'((10'd1 << nd) - 10'd1);

  // receiver
  logic [1:0]    rsync;
  logic          rxs;
  logic          ract;
  logic [CW-1:0] rcnt;
  logic [3:0]    rbit;
  logic [8:0]    rsh;
  logic [1:0]    zc;
  logic [1:0]    zc_n;
  logic          in_stop, mid, xfer, par_chk, par_bad, vote_end;
  logic [8:0]    rdata_now;

  assign rxs      = rsync[1];
  assign in_stop  = (rbit == nb + 4'd1);
  assign mid      = ract & baud_tick & (rcnt == CTR);
  assign vote_end = ract & baud_tick & in_stop & (rcnt == S_HI);
  assign xfer     = early ? (mid & (rbit == nb)) : vote_end;
  assign par_chk  = mid & hp & (rbit == nd + 4'd1);
  assign par_bad  = rxs ^ (^(rsh & dmask)) ^ par_odd;
  assign zc_n     = zc + {1'b0, ~rxs};
  assign rdata_now = (early & ~hp) ? {rxs, rsh[7:0]} : (rsh & dmask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync <= 2'b11;
      ract  <= 1'b0;
      rcnt  <= '0;
      rbit  <= '0;
      rsh   <= '0;
      zc    <= '0;
    end else begin
      rsync <= {rsync[0], rx};
      if (!ract) begin
        if (baud_tick && !rxs) begin
          ract <= 1'b1;
          rcnt <= CW'(1);
          rbit <= '0;
          rsh  <= '0;
        end
      end else if (baud_tick) begin
        rcnt <= rcnt + CW'(1);
        if (rcnt == LAST) rbit <= rbit + 4'd1;
        if (rcnt == CTR && rbit == 4'd0 && rxs) ract <= 1'b0;
        if (rcnt == CTR && rbit >= 4'd1 && rbit <= nd) rsh[rbit - 4'd1] <= rxs;
        if (in_stop) begin
          if (rcnt == S_LO) zc <= {1'b0, ~rxs};
          if (rcnt == CTR)  zc <= zc_n;
          if (rcnt == S_HI) ract <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_buf  <= '0;
      rx_full <= 1'b0;
      rx_irq  <= 1'b0;
      perr    <= 1'b0;
      ferr    <= 1'b0;
      oerr    <= 1'b0;
    end else begin
      rx_irq <= xfer;
      if (err_clr) begin
        perr <= 1'b0;
        ferr <= 1'b0;
        oerr <= 1'b0;
      end
      if (xfer) begin
        if (rx_full && !rd_ack) begin
          oerr <= 1'b1;
        end else begin
          rx_buf  <= rdata_now;
          rx_full <= 1'b1;
        end
      end else if (rd_ack) begin
        rx_full <= 1'b0;
      end
      if (par_chk && par_bad) perr <= 1'b1;
      if (vote_end && zc_n >= 2'd2) ferr <= 1'b1;
    end
  end

  // transmitter
  logic          tact, tpend, tpar;
  logic [CW-1:0] tcnt;
  logic [3:0]    tbit, tnb;
  logic [8:0]    tsh;

  assign tpar = (^(tx_data & dmask)) ^ par_odd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tact   <= 1'b0;
      tpend  <= 1'b0;
      tcnt   <= '0;
      tbit   <= '0;
      tnb    <= '0;
      tsh    <= '0;
      tx     <= 1'b1;
      tx_irq <= 1'b0;
    end else begin
      tx_irq <= 1'b0;
      if (tx_wr && !tact && !tpend) begin
        tpend <= 1'b1;
        tnb   <= nb;
        tsh   <= (tx_data & dmask) | (hp ? ({8'd0, tpar} << nd) : 9'd0);
      end
      if (tpend && baud_tick) begin
        tpend <= 1'b0;
        tact  <= 1'b1;
        tcnt  <= '0;
        tbit  <= '0;
        tx    <= 1'b0;
      end else if (tact && baud_tick) begin
        tcnt <= tcnt + CW'(1);
        if (tcnt == PRE && tbit == tnb) tx_irq <= 1'b1;
        if (tcnt == LAST) begin
          tbit <= tbit + 4'd1;
          if (tbit == tnb + 4'd1) tact <= 1'b0;
          else if (tbit < tnb)    tx   <= tsh[tbit];
          else                    tx   <= 1'b1;
        end
      end
    end
  end
endmodule

module uart_fmt_trx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_irq,
  input logic       rx_full,
  input logic [8:0] rx_buf,
  input logic       rd_ack,
  input logic       err_clr,
  input logic       perr,
  input logic       ferr,
  input logic       oerr,
  input logic       tx_irq
);
  a_r2_rx_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |=> !rx_irq);
  a_r7_full_on_irq: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> rx_full);
  a_r7_buf_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && !rd_ack) |=> $stable(rx_buf));
  a_r6_oerr_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oerr) |-> rx_irq);
  a_r12_ferr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ferr && !err_clr) |=> ferr);
  a_r12_perr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (perr && !err_clr) |=> perr);
  a_r12_oerr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (oerr && !err_clr) |=> oerr);
  a_r10_tx_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |=> !tx_irq);
endmodule

bind uart_fmt_trx uart_fmt_trx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_irq(rx_irq), .rx_full(rx_full),
  .rx_buf(rx_buf), .rd_ack(rd_ack), .err_clr(err_clr), .perr(perr),
  .ferr(ferr), .oerr(oerr), .tx_irq(tx_irq)
);

// File: tb/tb_uart_fmt_trx.sv
module tb_uart_fmt_trx;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic       baud_tick = 1'b0, rx = 1'b1, par_odd = 1'b0;
  logic [2:0] fmt = 3'd2;
  logic [8:0] tx_data = '0;
  logic       tx_wr = 1'b0, rd_ack = 1'b0, err_clr = 1'b0;
  logic       tx, rx_full, rx_irq, tx_irq, perr, ferr, oerr;
  logic [8:0] rx_buf;

  uart_fmt_trx dut (.*);

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  int tdiv = 0;
  always @(negedge clk) begin
    tdiv      <= (tdiv == 3) ? 0 : tdiv + 1;
    baud_tick <= (tdiv == 3);
  end
  int tick_num = 0;
  always @(posedge clk) if (baud_tick) tick_num <= tick_num + 1;

  task automatic wait_tick();
    do @(posedge clk); while (!baud_tick);
    @(negedge clk);
  endtask

  function automatic int f_nd(input logic [2:0] f);
    case (f) 3'd0, 3'd1: return 7; 3'd4: return 9; default: return 8; endcase
  endfunction
  function automatic int f_hp(input logic [2:0] f);
    return (f == 3'd1 || f == 3'd3) ? 1 : 0;
  endfunction

  // receive scoreboard
  typedef struct packed {
    logic [8:0] bv;
    logic       pe;
    logic       oe;
    logic       ack;
    logic [3:0] pos;
  } rxexp_t;
  rxexp_t rxq[$];
  int rx_pos = 15, rx_stop = 15;

  always @(negedge clk) begin
    rxexp_t it;
    rd_ack <= 1'b0;
    if (rx_irq) begin
      if (rxq.size() == 0) chk(0, "R8", "unexpected rx_irq", 1, 0);
      else begin
        it = rxq.pop_front();
        chk(rx_pos == int'(it.pos), it.pos == 4'(rx_stop) ? "R3" : "R2",
            "irq bit position", rx_pos, int'(it.pos));
        chk(rx_buf == it.bv, "R1", "rx_buf at irq", rx_buf, it.bv);
        chk(perr == it.pe, "R5", "perr at irq", perr, it.pe);
        chk(oerr == it.oe, "R6", "oerr at irq", oerr, it.oe);
        chk(rx_full == 1'b1, "R7", "rx_full at irq", rx_full, 1);
        if (it.ack) rd_ack <= 1'b1;
      end
    end
  end

  logic ferr_q = 1'b0;
  always @(negedge clk) begin
    if (ferr && !ferr_q)
      chk(rx_pos == rx_stop, "R4", "ferr rise position", rx_pos, rx_stop);
    ferr_q <= ferr;
  end

  task automatic send_rx(input logic [2:0] f, input logic [8:0] d,
                         input bit bad_par, input int stop_mode,
                         input bit ack_it, input bit exp_oe,
                         input logic [8:0] exp_bv, input bit exp_fe,
                         input string tag);
    int nd, hp, nb;
    logic [8:0] m;
    logic p;
    rxexp_t it;
    nd = f_nd(f); hp = f_hp(f); nb = nd + hp;
    m = 9'((10'd1 << nd) - 1);
    p = (^(d & m)) ^ par_odd ^ bad_par;
    fmt = f;
    rx_stop = nb + 1;
    it.bv = exp_bv; it.pe = bad_par & (hp == 1); it.oe = exp_oe;
    it.ack = ack_it; it.pos = (nb == 9) ? 4'(nb) : 4'(nb + 1);
    rxq.push_back(it);
    for (int k = 0; k <= nb + 1; k++) begin
      rx_pos = k;
      for (int o = 1; o <= 16; o++) begin
        if (k == 0) rx = 1'b0;
        else if (k <= nd) rx = d[k-1];
        else if (k <= nb) rx = p;
        else case (stop_mode)
          1: rx = !(o >= 8 && o <= 10);
          2: rx = (o != 9);
          3: rx = 1'b0;
          default: rx = 1'b1;
        endcase
        wait_tick();
      end
    end
    rx = 1'b1; rx_pos = 15;
    for (int i = 0; i < 4; i++) wait_tick();
    chk(rxq.size() == 0, tag, "frame produced irq", rxq.size(), 0);
    chk(ferr == exp_fe, "R4", "ferr after frame", ferr, exp_fe);
    err_clr = 1'b1; @(negedge clk); err_clr = 1'b0; @(negedge clk);
    chk({perr, ferr, oerr} == 3'b000, "R12", "flags after clear",
        {perr, ferr, oerr}, 0);
  endtask

  // transmit scoreboard
  logic [10:0] txq_bits[$];
  int          txq_n[$];
  int t0, last_tick, irq_off, tx_frames = 0, cur_n;
  bit tmon = 0, tx_q = 1;
  logic [10:0] got;

  always @(negedge clk) begin
    int off;
    if (!tmon && tx_q && !tx && rst_n) begin
      if (txq_n.size() == 0) chk(0, "R11", "unexpected tx frame", 1, 0);
      else begin
        tmon = 1; t0 = tick_num; last_tick = tick_num; got = '0;
        irq_off = -1; cur_n = txq_n[0];
      end
    end
    if (tmon) begin
      off = tick_num - t0;
      if (tx_irq) irq_off = off;
      if (tick_num != last_tick && off % 16 == 8) begin
        got[off / 16] = tx;
        if (off / 16 == cur_n + 1) begin
          chk(got == txq_bits[0], "R9", "tx frame bits", got, txq_bits[0]);
          chk(irq_off == 16 * (cur_n + 1) - 1, "R10", "tx_irq tick offset",
              irq_off, 16 * (cur_n + 1) - 1);
          void'(txq_bits.pop_front()); void'(txq_n.pop_front());
          tx_frames++; tmon = 0;
        end
      end
      last_tick = tick_num;
    end
    tx_q = tx;
  end

  task automatic send_tx(input logic [2:0] f, input logic [8:0] d,
                         input bit busy_write);
    int nd, hp;
    logic [8:0] m;
    logic [10:0] e;
    nd = f_nd(f); hp = f_hp(f);
    m = 9'((10'd1 << nd) - 1);
    e = '0;
    for (int i = 0; i < nd; i++) e[i+1] = d[i];
    if (hp == 1) e[nd+1] = (^(d & m)) ^ par_odd;
    e[nd+hp+1] = 1'b1;
    fmt = f;
    txq_bits.push_back(e); txq_n.push_back(nd + hp);
    tx_data = d; tx_wr = 1'b1; @(negedge clk); tx_wr = 1'b0;
    if (busy_write) begin
      for (int i = 0; i < 30; i++) wait_tick();
      tx_data = ~d; tx_wr = 1'b1; @(negedge clk); tx_wr = 1'b0;
    end
    while (tmon || txq_n.size() != 0) @(negedge clk);
    for (int i = 0; i < 40; i++) wait_tick();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int fr;
    repeat (4) @(negedge clk);
    // R13 reset state
    chk({tx, rx_full, rx_irq, tx_irq, perr, ferr, oerr} == 7'b1000000,
        "R13", "outputs in reset", {tx, rx_full, rx_irq, tx_irq, perr, ferr, oerr}, 7'b1000000);
    chk(rx_buf == 0, "R13", "rx_buf in reset", rx_buf, 0);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);

    // R1 / R2 / R3 formats
    send_rx(3'd0, 9'h055, 0, 0, 1, 0, 9'h055, 0, "R3");
    send_rx(3'd1, 9'h03A, 0, 0, 1, 0, 9'h03A, 0, "R3");
    send_rx(3'd2, 9'h1A5, 0, 0, 1, 0, 9'h0A5, 0, "R1");
    par_odd = 1'b1;
    send_rx(3'd3, 9'h0C3, 0, 0, 1, 0, 9'h0C3, 0, "R2");
    send_rx(3'd4, 9'h1B6, 0, 0, 1, 0, 9'h1B6, 0, "R2");
    // R5 parity errors, odd and even
    send_rx(3'd3, 9'h071, 1, 0, 1, 0, 9'h071, 0, "R5");
    par_odd = 1'b0;
    send_rx(3'd1, 9'h012, 1, 0, 1, 0, 9'h012, 0, "R5");
    // R4 majority vote
    send_rx(3'd2, 9'h03C, 0, 1, 1, 0, 9'h03C, 1, "R4");
    send_rx(3'd0, 9'h066, 0, 2, 1, 0, 9'h066, 0, "R4");
    send_rx(3'd4, 9'h101, 0, 3, 1, 0, 9'h101, 1, "R4");
    send_rx(3'd3, 9'h0E7, 0, 1, 1, 0, 9'h0E7, 1, "R4");
    // R6 / R7 overrun and double buffer
    send_rx(3'd2, 9'h011, 0, 0, 0, 0, 9'h011, 0, "R7");
    chk(rx_full == 1'b1, "R7", "rx_full held unread", rx_full, 1);
    send_rx(3'd2, 9'h0EE, 0, 0, 1, 1, 9'h011, 0, "R6");
    @(negedge clk);
    chk(rx_full == 1'b0, "R7", "rx_full after ack", rx_full, 0);
    chk(rx_buf == 9'h011, "R6", "rx_buf kept old word", rx_buf, 9'h011);
    // R8 false start
    rx = 1'b0;
    for (int i = 0; i < 4; i++) wait_tick();
    rx = 1'b1;
    for (int i = 0; i < 40; i++) wait_tick();
    chk(rx_full == 1'b0, "R8", "rx_full after glitch", rx_full, 0);
    chk(rx_buf == 9'h011, "R8", "rx_buf after glitch", rx_buf, 9'h011);
    send_rx(3'd2, 9'h05A, 0, 0, 1, 0, 9'h05A, 0, "R8");

    // transmitter R9 / R10 / R11
    chk(tx == 1'b1, "R9", "tx idle", tx, 1);
    send_tx(3'd0, 9'h055, 0);
    send_tx(3'd1, 9'h03B, 0);
    send_tx(3'd2, 9'h0C6, 0);
    par_odd = 1'b1;
    send_tx(3'd3, 9'h0A0, 0);
    send_tx(3'd4, 9'h153, 0);
    par_odd = 1'b0;
    fr = tx_frames;
    send_tx(3'd2, 9'h081, 1);
    chk(tx_frames == fr + 1, "R11", "frames after busy write", tx_frames, fr + 1);
    chk(tx == 1'b1, "R11", "tx idle after busy write", tx, 1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule